// File: doc/BRIEF.md
# Rotating Window Register File

This block is a general-purpose register file of 32-bit entries whose physical size is set by a parameter to 32 or 64 entries. Instructions never name a physical entry. They use 4-bit specifiers into a 16-entry logical view. A window base, counted in groups of four registers, places that view on the physical file. A call-style command moves the window forward by one, two or three groups (4, 8 or 12 registers). The matching return command moves it back by the amount that call used. Because consecutive windows overlap, the high logical registers of a caller become the low logical registers of the callee. Arguments and results therefore pass between them without any software save or restore.

The block has two combinational read ports and one write port. All three see the current window. A small stack records the increment code of every accepted call. An occupancy count, in groups of four, records how much of the physical file the live windows cover. When a call would need more registers than exist, the call is refused and a flag is raised. When a return is issued with no call outstanding, it is refused and a different flag is raised. Moving old windows to memory and back is left to the surrounding logic, which watches these flags.

A controller state machine has three states. RUN is normal operation. OVERFLOW is the cycle after a refused call. UNDERFLOW is the cycle after a refused return. From any state, a refused call goes to OVERFLOW. Otherwise a refused return goes to UNDERFLOW. Every other cycle goes to RUN. Reset enters RUN.

Top module: `wrf_rotfile`

## Requirements
- R1: Logical specifier i maps to physical entry (window_base*4 + i) modulo PHYS_REGS, with PHYS_REGS set to 32 or 64 and each entry 32 bits wide. After a call of code k, the callee's logical register j is the same entry as the caller's logical register 4k+j.
- R2: Both read ports return, in the same cycle and without a clock, the entry that their own specifier selects in the current window. The two ports act independently.
- R3: When wr_en is 1, wr_data is stored at the clock edge into the entry that wr_idx selects in the current window. When wr_en is 0, no entry changes.
- R4: When wr_en is 1 and a read port selects the same physical entry as the write port, that read port returns wr_data in the same cycle (write-through bypass).
- R5: A call (rot_call=1) with rot_amt code 1, 2 or 3 is accepted if occupancy + code does not exceed PHYS_REGS/4. An accepted call adds the code to win_base at the next edge and pushes the code onto the stack.
- R6: A call with rot_amt code 0 is ignored: win_base does not change, nothing is pushed, and no flag is raised.
- R7: A return (rot_ret=1) with at least one call outstanding pops the newest code and subtracts it from win_base at the next edge, restoring the base the matching call started from.
- R8: Occupancy starts at 4 groups (one window) and goes up or down by each accepted call or return. A call that would take occupancy above PHYS_REGS/4 is refused: win_base stays unchanged, and ovf_flag is 1 for exactly the next cycle (state OVERFLOW).
- R9: A return with no call outstanding is refused: win_base stays unchanged, and unf_flag is 1 for exactly the next cycle (state UNDERFLOW).
- R10: When rot_call and rot_ret are both 1 in one cycle, the call is served and the return is ignored.
- R11: Reset sets win_base to 0, empties the stack, sets occupancy to one window, and clears both flags (state RUN). Register contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Logical specifier, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical specifier, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical specifier, write port |
| wr_data | input | 32 | Write data |
| rot_call | input | 1 | Rotate window forward |
| rot_amt | input | 2 | Increment code in groups of four (0 = no-op) |
| rot_ret | input | 1 | Rotate window back by the newest recorded code |
| win_base | output | 4 | Current window base in groups of four |
| ovf_flag | output | 1 | Previous call was refused for lack of capacity |
| unf_flag | output | 1 | Previous return found no outstanding call |

## Verification
A corrupted stack entry or stack pointer shows up on the first return that uses it. win_base then comes back to the wrong value one cycle later, and reads through both ports return another window's data in that same cycle. An occupancy count that is wrong gives a visible result only at the capacity limit. There, a legal call is refused or an illegal one succeeds, which flips ovf_flag and win_base in the cycle after the call. The bench therefore fills the file up to the limit and then unwinds it past empty. Errors in the base-to-index mapping show on the very next combinational read after a rotation, and the overlap reads target exactly those.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    // Controller states
    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_OVF = 2'd1,
        ST_UNF = 2'd2
    } wrf_state_e;

    localparam int GROUP_REGS = 4;   // registers per window step unit
    localparam int AMT_W      = 2;   // width of the increment code
endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
    parameter int PHYS_REGS = 64,
    parameter int IDX_W     = 4,
    localparam int BASE_W   = $clog2(PHYS_REGS / wrf_pkg::GROUP_REGS),
    localparam int PIDX_W   = $clog2(PHYS_REGS)
) (
    input  logic [BASE_W-1:0] base_u,
    input  logic [IDX_W-1:0]  log_idx,
    output logic [PIDX_W-1:0] phys_idx
);
    // Base counts groups of four; the sum wraps modulo PHYS_REGS by width.
    assign phys_idx = PIDX_W'({base_u, 2'b00}) + PIDX_W'(log_idx);
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
    parameter int DATA_W    = 32,
    parameter int PHYS_REGS = 64,
    parameter int RD_PORTS  = 2,
    localparam int PIDX_W   = $clog2(PHYS_REGS)
) (
    input  logic                             clk,
    input  logic                             wr_en,
    input  logic [PIDX_W-1:0]                wr_phys,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [RD_PORTS-1:0][PIDX_W-1:0]  rd_phys,
    output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] mem_q [PHYS_REGS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_phys] <= wr_data;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        // Same-cycle write to the selected entry is forwarded.
        assign rd_data[p] = (wr_en && (wr_phys == rd_phys[p])) ? wr_data
                                                                : mem_q[rd_phys[p]];
    end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
    import wrf_pkg::*;
#(
    parameter int PHYS_REGS = 64,
    parameter int WIN_REGS  = 16,
    localparam int UNITS     = PHYS_REGS / GROUP_REGS,
    localparam int WIN_UNITS = WIN_REGS / GROUP_REGS,
    localparam int STK_DEPTH = UNITS - WIN_UNITS,
    localparam int BASE_W    = $clog2(UNITS),
    localparam int OCC_W     = $clog2(UNITS + 1),
    localparam int SP_W      = $clog2(STK_DEPTH + 1),
    localparam int SIDX_W    = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rot_call,
    input  logic [AMT_W-1:0]  rot_amt,
    input  logic              rot_ret,
    output logic [BASE_W-1:0] base_q,
    output logic              ovf_flag,
    output logic              unf_flag
);
    wrf_state_e        st_q, st_d;
    logic [AMT_W-1:0]  stk_q [STK_DEPTH];
    logic [SP_W-1:0]   sp_q;
    logic [OCC_W-1:0]  occ_q;

    logic              call_v, ret_v, call_ok, ret_ok;
    logic [OCC_W:0]    occ_try;
    logic [AMT_W-1:0]  top_code;

    assign call_v   = rot_call && (rot_amt != '0);
    assign ret_v    = rot_ret && !rot_call;          // call wins a collision
    assign occ_try  = {1'b0, occ_q} + (OCC_W+1)'(rot_amt);
    assign call_ok  = call_v && (occ_try <= (OCC_W+1)'(UNITS));
    assign ret_ok   = ret_v && (sp_q != '0);
    assign top_code = (sp_q == '0) ? '0 : stk_q[SIDX_W'(sp_q - 1'b1)];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = ST_RUN;
        unique case (st_q)
            ST_RUN, ST_OVF, ST_UNF: begin
                if (call_v && !call_ok) begin
                    st_d = ST_OVF;
                end else if (ret_v && !ret_ok) begin
                    st_d = ST_UNF;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        ovf_flag = 1'b0;
        unf_flag = 1'b0;
        unique case (st_q)
            ST_RUN: ;
            ST_OVF: ovf_flag = 1'b1;
            ST_UNF: unf_flag = 1'b1;
            default: ;
        endcase
    end

    // Window base, occupancy and stack pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            occ_q  <= OCC_W'(WIN_UNITS);
            sp_q   <= '0;
        end else if (call_ok) begin
            base_q <= base_q + BASE_W'(rot_amt);
            occ_q  <= occ_q + OCC_W'(rot_amt);
            sp_q   <= sp_q + 1'b1;
        end else if (ret_ok) begin
            base_q <= base_q - BASE_W'(top_code);
            occ_q  <= occ_q - OCC_W'(top_code);
            sp_q   <= sp_q - 1'b1;
        end
    end

    // Stack storage of increment codes
    always_ff @(posedge clk) begin
        if (call_ok) begin
            stk_q[SIDX_W'(sp_q)] <= rot_amt;
        end
    end
endmodule

// File: rtl/wrf_rotfile.sv
module wrf_rotfile
    import wrf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PHYS_REGS = 64,
    parameter int WIN_REGS  = 16,
    localparam int IDX_W    = $clog2(WIN_REGS),
    localparam int BASE_W   = $clog2(PHYS_REGS / GROUP_REGS),
    localparam int PIDX_W   = $clog2(PHYS_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rot_call,
    input  logic [AMT_W-1:0]  rot_amt,
    input  logic              rot_ret,
    output logic [BASE_W-1:0] win_base,
    output logic              ovf_flag,
    output logic              unf_flag
);
    localparam int N_MAP = 3;   // port A, port B, write

    logic [N_MAP-1:0][IDX_W-1:0]  log_idx;
    logic [N_MAP-1:0][PIDX_W-1:0] phys_idx;
    logic [1:0][DATA_W-1:0]       rd_data;

    assign log_idx = {wr_idx, rd_b_idx, rd_a_idx};

    wrf_ctrl #(
        .PHYS_REGS (PHYS_REGS),
        .WIN_REGS  (WIN_REGS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rot_call (rot_call),
        .rot_amt  (rot_amt),
        .rot_ret  (rot_ret),
        .base_q   (win_base),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag)
    );

    for (genvar m = 0; m < N_MAP; m++) begin : g_map
        wrf_map #(
            .PHYS_REGS (PHYS_REGS),
            .IDX_W     (IDX_W)
        ) u_map (
            .base_u   (win_base),
            .log_idx  (log_idx[m]),
            .phys_idx (phys_idx[m])
        );
    end

    wrf_store #(
        .DATA_W    (DATA_W),
        .PHYS_REGS (PHYS_REGS),
        .RD_PORTS  (2)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_phys (phys_idx[2]),
        .wr_data (wr_data),
        .rd_phys (phys_idx[1:0]),
        .rd_data (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
endmodule

// File: rtl/wrf_rotfile_chk.sv
module wrf_rotfile_chk #(
    parameter int DATA_W    = 32,
    parameter int PHYS_REGS = 64,
    parameter int WIN_REGS  = 16,
    localparam int IDX_W    = $clog2(WIN_REGS),
    localparam int BASE_W   = $clog2(PHYS_REGS / 4)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [IDX_W-1:0]  rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              rot_call,
    input logic [1:0]        rot_amt,
    input logic              rot_ret,
    input logic [BASE_W-1:0] win_base,
    input logic              ovf_flag,
    input logic              unf_flag
);
    // R8 / R9: the two refusal flags never coincide
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));

    // R8: a refused call leaves the base where it was
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (win_base == $past(win_base)));

    // R9: a refused return leaves the base where it was
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> (win_base == $past(win_base)));

    // R4: same logical index on read and write returns the write data
    p_bypass_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_a_idx == wr_idx)) |-> (rd_a_data == wr_data));

    p_bypass_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_b_idx == wr_idx)) |-> (rd_b_data == wr_data));

    // R5: a call either advances the base by its code or is refused
    p_call_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_call && (rot_amt != 2'd0)) |=>
            (ovf_flag || (win_base == BASE_W'($past(win_base) + BASE_W'($past(rot_amt))))));

    // R6: a zero-code call changes nothing
    p_zero_call_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_call && (rot_amt == 2'd0)) |=> ((win_base == $past(win_base)) && !ovf_flag));

    // R7: a lone return either moves the base back or is refused
    p_ret_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_ret && !rot_call) |=> (unf_flag || (win_base < $past(win_base))));
endmodule

bind wrf_rotfile wrf_rotfile_chk #(
    .DATA_W    (DATA_W),
    .PHYS_REGS (PHYS_REGS),
    .WIN_REGS  (WIN_REGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rot_call  (rot_call),
    .rot_amt   (rot_amt),
    .rot_ret   (rot_ret),
    .win_base  (win_base),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/test_wrf_rotfile.sv
module test_wrf_rotfile;
    localparam int NP    = 64;
    localparam int UNITS = NP / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, rot_call = 1'b0, rot_ret = 1'b0;
    logic [1:0]  rot_amt = '0;
    logic [3:0]  win_base;
    logic        ovf_flag, unf_flag;

    always #4 clk = ~clk;   // 125 MHz

    wrf_rotfile #(.DATA_W(32), .PHYS_REGS(NP), .WIN_REGS(16)) i_wrf_rotfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rot_call(rot_call), .rot_amt(rot_amt), .rot_ret(rot_ret),
        .win_base(win_base), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    typedef struct {
        int          kind;   // 0 rd_a, 1 rd_b, 2 ovf, 3 unf, 4 base
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model
    logic [31:0] mreg [NP];
    int          mbase = 0;
    int          occ = 4;
    int          stk[$];
    bit          pend_ovf = 1'b0, pend_unf = 1'b0;

    function automatic int phys(input int i);
        return (mbase * 4 + i) % NP;
    endfunction

    task automatic step(input string tag, input bit call, input int amt, input bit ret,
                        input bit we, input int widx, input logic [31:0] wd,
                        input int ra, input int rb);
        int pa, pb, pw;
        bit nov, nun;
        @(posedge clk); #1;
        rot_call = call; rot_amt = 2'(amt); rot_ret = ret;
        wr_en = we; wr_idx = 4'(widx); wr_data = wd;
        rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
        pa = phys(ra); pb = phys(rb); pw = phys(widx);
        sb.push_back('{0, (we && pw == pa) ? wd : mreg[pa], tag});
        sb.push_back('{1, (we && pw == pb) ? wd : mreg[pb], tag});
        sb.push_back('{2, 32'(pend_ovf), tag});
        sb.push_back('{3, 32'(pend_unf), tag});
        sb.push_back('{4, 32'(mbase), tag});
        if (we) mreg[pw] = wd;
        nov = 1'b0; nun = 1'b0;
        if (call && amt != 0) begin
            if (occ + amt <= UNITS) begin
                stk.push_back(amt); mbase += amt; occ += amt;
            end else nov = 1'b1;
        end else if (ret && !call) begin
            if (stk.size() == 0) nun = 1'b1;
            else begin
                int c;
                c = stk.pop_back(); mbase -= c; occ -= c;
            end
        end
        pend_ovf = nov; pend_unf = nun;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        rot_call = 1'b0; rot_ret = 1'b0; wr_en = 1'b0; rot_amt = '0;
        mbase = 0; occ = 4; stk.delete(); pend_ovf = 1'b0; pend_unf = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // Monitor: compares every expected item in the cycle it was issued for
    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        while (sb.size() > 0) begin
            it = sb.pop_front();
            case (it.kind)
                0: act = rd_a_data;
                1: act = rd_b_data;
                2: act = 32'(ovf_flag);
                3: act = 32'(unf_flag);
                default: act = 32'(win_base);
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    initial begin
        #1;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11: state after reset, read through bypass
        step("R11", 0, 0, 0, 1, 0, 32'h1111_0000, 0, 0);
        // Fill every physical entry across five windows; R3 writes, R1 overlap
        for (int w = 0; w < 5; w++) begin
            if (w > 0) begin
                step("R5", 1, 3, 0, 0, 0, 0, 15, 15);
                for (int j = 0; j < 4; j++) step("R1", 0, 0, 0, 0, 0, 0, j, 3 - j);
            end
            for (int j = 0; j < 16; j++)
                step("R3", 0, 0, 0, 1, j, 32'hA000_0000 | (w << 8) | j, j, j);
        end
        // R2: independent reads in the top window
        step("R2", 0, 0, 0, 0, 0, 0, 2, 13);
        // R8: occupancy full, call refused
        step("R8", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 1, 2);
        step("R8", 0, 0, 0, 0, 0, 0, 1, 2);
        // R6: zero-code call
        step("R6", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 0, 4, 5);
        // R3: write with enable low has no effect
        step("R3", 0, 0, 0, 0, 5, 32'hDEAD_BEEF, 5, 5);
        step("R3", 0, 0, 0, 0, 0, 0, 5, 6);
        // R4: bypass on one port, plain read on the other
        step("R4", 0, 0, 0, 1, 7, 32'h7777_7777, 7, 8);
        step("R4", 0, 0, 0, 0, 0, 0, 7, 8);
        // R7: return, then R10 call and return together
        step("R7", 0, 0, 1, 0, 0, 0, 0, 15);
        step("R10", 1, 1, 1, 0, 0, 0, 3, 12);
        step("R10", 0, 0, 0, 0, 0, 0, 3, 12);
        // R7: unwind every call
        for (int k = 0; k < 4; k++) step("R7", 0, 0, 1, 0, 0, 0, k, 15 - k);
        step("R7", 0, 0, 0, 0, 0, 0, 0, 15);
        // R9: return with nothing outstanding
        step("R9", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 1, 1);
        step("R9", 0, 0, 0, 0, 0, 0, 1, 1);
        // R6: zero-code call pushes nothing, so the next return underflows
        step("R6", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 0, 0, 0);
        // R5 / R7: mixed codes and exact restore
        step("R5", 1, 2, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 1, 0, 0, 0, 0, 0, 4);
        step("R7", 0, 0, 1, 0, 0, 0, 3, 12);
        step("R7", 0, 0, 1, 0, 0, 0, 3, 12);
        step("R7", 0, 0, 0, 0, 0, 0, 3, 12);
        // R11: reset mid-run clears base and stack, keeps contents
        step("R11", 1, 3, 0, 0, 0, 0, 0, 0);
        do_reset();
        step("R11", 0, 0, 1, 0, 0, 0, 9, 10);
        step("R11", 0, 0, 0, 0, 0, 0, 9, 10);
        step("R2", 0, 0, 0, 0, 0, 0, 11, 14);
        @(negedge clk); #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule